// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. Software programs it through a small register port: a control byte, a source address, a destination address and a transfer count. An outside event arrives as a one-cycle request strobe and is latched as a pending request. While the channel is enabled and a request is pending, the channel asks for the bus, reads one unit from the source and then writes it to the destination. The unit is either a byte or a 16-bit word.

After each write, every address set to forward mode advances by the unit size and the counter decrements. When the counter reaches its terminal value, the channel pulses a completion output. In single mode it then disables itself. In repeat mode it reloads the counter and both addresses from the values software last wrote, and it stays enabled. The bus arbiter, the memory and the choice of request source are outside the block.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the control register reads 0, `bus_req` is 0 and `xfer_done` is 0.
- R2: The control register (select 0) holds these fields: bit 0 is the unit (1 = byte, 0 = word), bit 1 is repeat mode, bit 2 is request pending, bit 3 is enable, bit 4 is source forward and bit 5 is destination forward. Bits above 5 read 0 and ignore writes. A write that sets both bit 4 and bit 5 stores bit 5 as 0.
- R3: A `req_strobe` pulse sets the pending bit. A register write with bit 2 = 0 clears it. A write with bit 2 = 1 leaves it unchanged.
- R4: The channel asserts `bus_req` only while a transfer is in progress. A transfer starts only when both enable and pending are 1. With enable at 0, a pending request never raises `bus_req`.
- R5: Each transfer is one read cycle at the source address followed by one write cycle at the destination address. The write carries the data that was read. A bus cycle (`bus_cyc`) happens only in a cycle where `bus_gnt` is 1, and a low grant stalls the transfer.
- R6: `bus_byte` equals the unit bit. A forward address advances by 1 in byte mode and by 2 in word mode.
- R7: An address whose direction bit is 0 keeps its value across transfers.
- R8: The count register (select 3) decreases by one with each completed transfer and reads back its current value. The source and destination addresses are at selects 1 and 2.
- R9: In single mode, the transfer that moves the count from 1 to 0 ends the block. The enable bit then reads 0, and `xfer_done` is high for exactly one cycle.
- R10: In repeat mode, the terminal transfer reloads the count and both addresses from their last written values. Enable stays 1, and `xfer_done` pulses for one cycle.
- R11: Starting a transfer consumes the pending request, so the pending bit reads 0 afterwards unless a new strobe has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 count |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data for `reg_sel` |
| req_strobe | input | 1 | One-cycle transfer request event |
| bus_req | output | 1 | Bus request, high during a transfer |
| bus_gnt | input | 1 | Bus grant |
| bus_cyc | output | 1 | A bus cycle takes place this clock |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_byte | output | 1 | 1 = byte transfer, 0 = word transfer |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid in a granted read cycle |
| xfer_done | output | 1 | One-cycle pulse after a terminal-count transfer |

## Verification
The bench builds the block with its defaults: 16-bit addresses, count and data, and a 16-bit register port. With these values, word and byte units, every pair of address directions, and counts of one to six all fit in short runs. The grant is withheld at random, which brings stalled read and write cycles within reach. Repeat mode is taken through two wraps of the counter, so the reload of count and forward address is seen more than once.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_READ  = 2'd1,
        XS_WRITE = 2'd2
    } xfer_state_e;

    // packed so that field order equals bit order in the control byte
    typedef struct packed {
        logic dst_fwd;
        logic src_fwd;
        logic enable;
        logic pending;
        logic repeat_md;
        logic byte_unit;
    } dma_ctrl_t;

    localparam int CTRL_BITS = 6;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_SRC  = 2'd1;
    localparam logic [1:0] SEL_DST  = 2'd2;
    localparam logic [1:0] SEL_CNT  = 2'd3;

endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
    import dma_chan_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CTRL_BITS-1:0] wdata,
    input  logic                 req_strobe,
    input  logic                 consume,
    input  logic                 tc_stop,
    output dma_ctrl_t            ctrl_o
);

    dma_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (consume) ctrl_d.pending = 1'b0;
        if (tc_stop) ctrl_d.enable  = 1'b0;
        if (wr_en) begin
            ctrl_d.byte_unit = wdata[0];
            ctrl_d.repeat_md = wdata[1];
            ctrl_d.enable    = wdata[3];
            ctrl_d.src_fwd   = wdata[4];
            ctrl_d.dst_fwd   = wdata[5] & ~wdata[4];
            if (!wdata[2]) ctrl_d.pending = 1'b0;
        end
        if (req_strobe) ctrl_d.pending = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;

    // R3
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_strobe |=> ctrl_q.pending);

    // R3
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[2] && !req_strobe && !consume) |=> $stable(ctrl_q.pending));

    // R2
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[4]) |=> !ctrl_q.dst_fwd);

    // R9
    stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_stop && !wr_en) |=> !ctrl_q.enable);

    // R11
    consume_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !req_strobe) |=> !ctrl_q.pending);

endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wdata,
    input  logic          step,
    input  logic          repeat_md,
    output logic [CW-1:0] cnt_o,
    output logic          tc_o
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] rld;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    at_last;

    assign at_last = (st_q.cnt == CNT_ONE);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cnt = wdata;
            st_d.rld = wdata;
        end else if (step) begin
            if (at_last && repeat_md) st_d.cnt = st_q.rld;
            else                      st_d.cnt = st_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign tc_o  = step && at_last;

    // R8
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en && st_q.cnt != CNT_ONE) |=> st_q.cnt == $past(st_q.cnt) - CNT_ONE);

    // R10
    cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en && st_q.cnt == CNT_ONE && repeat_md) |=> st_q.cnt == st_q.rld);

    // R9
    cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en && st_q.cnt == CNT_ONE && !repeat_md) |=> st_q.cnt == '0);

endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wdata,
    input  logic          step,
    input  logic          fwd,
    input  logic          byte_unit,
    input  logic          reload,
    output logic [AW-1:0] addr_o
);

    localparam logic [AW-1:0] INC_BYTE = AW'(1);
    localparam logic [AW-1:0] INC_WORD = AW'(2);

    typedef struct packed {
        logic [AW-1:0] cur;
        logic [AW-1:0] rld;
    } addr_st_t;

    addr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cur = wdata;
            st_d.rld = wdata;
        end else if (step) begin
            if (reload)   st_d.cur = st_q.rld;
            else if (fwd) st_d.cur = st_q.cur + (byte_unit ? INC_BYTE : INC_WORD);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.cur;

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !fwd && !reload && !wr_en) |=> $stable(st_q.cur));

    // R6
    addr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && fwd && !reload && !wr_en) |=>
            st_q.cur == $past(st_q.cur) + ($past(byte_unit) ? INC_BYTE : INC_WORD));

    // R10
    addr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && reload && !wr_en) |=> st_q.cur == st_q.rld);

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          bus_gnt,
    input  logic [DW-1:0] bus_rdata,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    output logic          bus_req,
    output logic          bus_cyc,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          consume,
    output logic          step
);

    typedef struct packed {
        xfer_state_e   st;
        logic [DW-1:0] hold;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        consume = 1'b0;
        step    = 1'b0;
        unique case (st_q.st)
            XS_IDLE: begin
                if (go) begin
                    consume = 1'b1;
                    st_d.st = XS_READ;
                end
            end
            XS_READ: begin
                if (bus_gnt) begin
                    st_d.hold = bus_rdata;
                    st_d.st   = XS_WRITE;
                end
            end
            XS_WRITE: begin
                if (bus_gnt) begin
                    step    = 1'b1;
                    st_d.st = XS_IDLE;
                end
            end
            default: st_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: XS_IDLE, hold: '0};
        else        st_q <= st_d;
    end

    assign bus_req   = (st_q.st != XS_IDLE);
    assign bus_cyc   = bus_req && bus_gnt;
    assign bus_we    = (st_q.st == XS_WRITE);
    assign bus_addr  = bus_we ? dst_addr : src_addr;
    assign bus_wdata = st_q.hold;

    // R4
    go_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == XS_IDLE && go) |=> st_q.st == XS_READ);

    // R5
    wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == XS_READ && bus_gnt) |=> st_q.st == XS_WRITE);

    // R5
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == XS_WRITE) |-> ($past(st_q.st) == XS_READ || $past(st_q.st) == XS_WRITE));

    // R5
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st != XS_IDLE && !bus_gnt) |=> $stable(st_q.st));

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic          req_strobe,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_cyc,
    output logic          bus_we,
    output logic          bus_byte,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          xfer_done
);

    localparam int N_ADDR = 2;
    localparam int IDX_SRC = 0;
    localparam int IDX_DST = 1;

    typedef struct packed {
        logic done;
    } top_st_t;

    dma_ctrl_t     ctrl;
    logic          consume, step, tc, tc_stop, tc_reload, go;
    logic [CW-1:0] cnt;
    logic [N_ADDR-1:0] a_wr, a_fwd;
    logic [AW-1:0] a_val [N_ADDR];
    top_st_t       top_d, top_q;

    assign go        = ctrl.enable && ctrl.pending;
    assign tc_stop   = tc && !ctrl.repeat_md;
    assign tc_reload = tc && ctrl.repeat_md;

    assign a_wr[IDX_SRC]  = reg_wr && (reg_sel == SEL_SRC);
    assign a_wr[IDX_DST]  = reg_wr && (reg_sel == SEL_DST);
    assign a_fwd[IDX_SRC] = ctrl.src_fwd;
    assign a_fwd[IDX_DST] = ctrl.dst_fwd;

    dma_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr && (reg_sel == SEL_CTRL)),
        .wdata      (reg_wdata[CTRL_BITS-1:0]),
        .req_strobe (req_strobe),
        .consume    (consume),
        .tc_stop    (tc_stop),
        .ctrl_o     (ctrl)
    );

    dma_count_unit #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr && (reg_sel == SEL_CNT)),
        .wdata     (reg_wdata[CW-1:0]),
        .step      (step),
        .repeat_md (ctrl.repeat_md),
        .cnt_o     (cnt),
        .tc_o      (tc)
    );

    for (genvar g = 0; g < N_ADDR; g++) begin : g_addr
        dma_addr_unit #(.AW(AW)) u_addr (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (a_wr[g]),
            .wdata     (reg_wdata[AW-1:0]),
            .step      (step),
            .fwd       (a_fwd[g]),
            .byte_unit (ctrl.byte_unit),
            .reload    (tc_reload),
            .addr_o    (a_val[g])
        );
    end

    dma_xfer_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .bus_gnt   (bus_gnt),
        .bus_rdata (bus_rdata),
        .src_addr  (a_val[IDX_SRC]),
        .dst_addr  (a_val[IDX_DST]),
        .bus_req   (bus_req),
        .bus_cyc   (bus_cyc),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .consume   (consume),
        .step      (step)
    );

    always_comb begin
        top_d      = top_q;
        top_d.done = tc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign xfer_done = top_q.done;
    assign bus_byte  = ctrl.byte_unit;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CTRL: reg_rdata[CTRL_BITS-1:0] = ctrl;
            SEL_SRC:  reg_rdata[AW-1:0]        = a_val[IDX_SRC];
            SEL_DST:  reg_rdata[AW-1:0]        = a_val[IDX_DST];
            default:  reg_rdata[CW-1:0]        = cnt;
        endcase
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R4
    no_req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && !ctrl.enable) |=> !bus_req);

    // R10
    rep_stay_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_reload && !reg_wr) |=> ctrl.enable);

endmodule

// File: tb/dma_chan_engine_bench.sv
module dma_chan_engine_bench;

    localparam int AW = 16;
    localparam int CW = 16;
    localparam int DW = 16;
    localparam int RW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic          req_strobe = 1'b0;
    logic          bus_req, bus_cyc, bus_we, bus_byte, xfer_done;
    logic          bus_gnt = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;

    int  n_chk = 0;
    int  n_bad = 0;
    int  n_done = 0;
    int  cyc = 0;
    bit  finished = 0;

    // bench-side model of the expected bus traffic
    logic [AW-1:0] m_src, m_dst, m_src_r, m_dst_r;
    logic [CW-1:0] m_cnt, m_cnt_r;
    bit m_byte, m_rep, m_sf, m_df, rd_seen, done_exp;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] mem_rd(logic [AW-1:0] a);
        return {a[7:0] ^ 8'hA5, a[15:8] ^ 8'h3C};
    endfunction

    function automatic logic [AW-1:0] step_of(bit b);
        return b ? AW'(1) : AW'(2);
    endfunction

    function automatic logic [7:0] ctrl_val(bit b, bit r, bit p, bit e, bit s, bit d);
        return {2'b00, d, s, e, p, r, b};
    endfunction

    assign bus_rdata = mem_rd(bus_addr);

    dma_chan_engine #(.AW(AW), .CW(CW), .DW(DW), .RW(RW)) u_dma_chan_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_strobe(req_strobe),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cyc(bus_cyc), .bus_we(bus_we),
        .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .xfer_done(xfer_done)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(logic [1:0] s, logic [RW-1:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] s, output logic [RW-1:0] v);
        reg_sel = s;
        @(negedge clk);
        v = reg_rdata;
        tick();
    endtask

    task automatic strobe();
        req_strobe = 1'b1;
        tick();
        req_strobe = 1'b0;
    endtask

    task automatic xfer_one();
        int t = 0;
        strobe();
        tick();
        tick();
        while (bus_req && t < 200) begin
            tick();
            t++;
        end
        tick();
    endtask

    task automatic cfg(logic [AW-1:0] s, logic [AW-1:0] d, logic [CW-1:0] c,
                       bit b, bit r, bit sf, bit df);
        wr(2'd0, 16'h0000);
        wr(2'd1, s);
        wr(2'd2, d);
        wr(2'd3, c);
        m_src = s; m_dst = d; m_cnt = c;
        m_src_r = s; m_dst_r = d; m_cnt_r = c;
        m_byte = b; m_rep = r; m_sf = sf; m_df = df && !sf;
        rd_seen = 0;
        wr(2'd0, {8'h00, ctrl_val(b, r, 1'b0, 1'b1, sf, df)});
    endtask

    // random grant, changed just after each rising edge
    always begin
        @(posedge clk);
        #2;
        bus_gnt = ($urandom % 3) != 0;
    end

    // bus monitor, samples between edges
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (xfer_done || done_exp) chk("R9/R10 done pulse", xfer_done, done_exp);
            if (xfer_done) n_done++;
            done_exp = 0;
            if (bus_cyc) begin
                chk("R6 bus_byte", bus_byte, m_byte);
                if (!bus_we) begin
                    chk("R5 read address", bus_addr, m_src);
                    rd_seen = 1;
                end else begin
                    chk("R5 read before write", rd_seen, 1);
                    chk("R5 write address", bus_addr, m_dst);
                    if (m_byte) chk("R5 write data byte", bus_wdata[7:0], mem_rd(m_src) & 16'h00FF);
                    else        chk("R5 write data word", bus_wdata, mem_rd(m_src));
                    rd_seen = 0;
                    if (m_cnt == CW'(1)) done_exp = 1;
                    if (m_cnt == CW'(1) && m_rep) begin
                        m_src = m_src_r; m_dst = m_dst_r; m_cnt = m_cnt_r;
                    end else begin
                        if (m_sf) m_src = m_src + step_of(m_byte);
                        if (m_df) m_dst = m_dst + step_of(m_byte);
                        m_cnt = m_cnt - CW'(1);
                    end
                end
            end
        end
    end

    task automatic summary();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=below 150000", cyc);
            summary();
        end
    end

    initial begin
        logic [RW-1:0] v;
        int d0;
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(2'd0, v);
        chk("R1 ctrl after reset", v, 16'h0000);
        chk("R1 bus_req after reset", bus_req, 1'b0);
        chk("R1 done after reset", xfer_done, 1'b0);

        // R2 upper bits ignored, both directions forced apart, pending write of 1 ignored
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v);
        chk("R2 ctrl all-ones write", v, 16'h001B);
        wr(2'd0, 16'h0000);

        // R3 / R4 request latch with channel disabled
        strobe();
        rd(2'd0, v);
        chk("R3 strobe sets pending", v, 16'h0004);
        d0 = 0;
        repeat (5) begin
            tick();
            if (bus_req) d0++;
        end
        chk("R4 no request while disabled", d0, 0);
        wr(2'd0, 16'h0004);
        rd(2'd0, v);
        chk("R3 write one keeps pending", v, 16'h0004);
        wr(2'd0, 16'h0000);
        rd(2'd0, v);
        chk("R3 write zero clears pending", v, 16'h0000);

        // word, source forward, destination fixed, single mode
        d0 = n_done;
        cfg(16'h1000, 16'h8000, 16'd3, 1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            xfer_one();
            rd(2'd3, v);
            chk("R8 count after transfer", v, 16'(2 - i));
            rd(2'd0, v);
            chk("R11 pending consumed", v[2], 1'b0);
        end
        rd(2'd0, v);
        chk("R9 enable cleared at terminal count", v, 16'h0010);
        rd(2'd1, v);
        chk("R6 word source advance", v, 16'h1006);
        rd(2'd2, v);
        chk("R7 fixed destination", v, 16'h8000);
        chk("R9 one done pulse", n_done - d0, 1);
        strobe();
        d0 = 0;
        repeat (5) begin
            tick();
            if (bus_req) d0++;
        end
        chk("R4 no transfer after block end", d0, 0);

        // byte, destination forward, source fixed
        cfg(16'h2001, 16'h3000, 16'd4, 1'b1, 1'b0, 1'b0, 1'b1);
        repeat (4) xfer_one();
        rd(2'd2, v);
        chk("R6 byte destination advance", v, 16'h3004);
        rd(2'd1, v);
        chk("R7 fixed source", v, 16'h2001);
        rd(2'd3, v);
        chk("R8 count at zero", v, 16'h0000);

        // repeat mode, two wraps and one more transfer
        d0 = n_done;
        cfg(16'h4000, 16'h5000, 16'd2, 1'b0, 1'b1, 1'b1, 1'b0);
        repeat (5) xfer_one();
        rd(2'd0, v);
        chk("R10 enable stays in repeat", v, 16'h000A | 16'h0010);
        rd(2'd3, v);
        chk("R10 count reloaded", v, 16'h0001);
        rd(2'd1, v);
        chk("R10 source reloaded", v, 16'h4002);
        chk("R10 done pulses", n_done - d0, 2);

        // random single-mode blocks
        for (int k = 0; k < 25; k++) begin
            logic [AW-1:0] s, d;
            logic [CW-1:0] c;
            bit b, sf, df, dfe;
            s = AW'($urandom); d = AW'($urandom);
            c = CW'(1 + $urandom % 6);
            b = $urandom % 2; sf = $urandom % 2; df = $urandom % 2;
            dfe = df && !sf;
            d0 = n_done;
            cfg(s, d, c, b, 1'b0, sf, df);
            rd(2'd0, v);
            chk("R2 random ctrl readback", v, {8'h00, ctrl_val(b, 1'b0, 1'b0, 1'b1, sf, dfe)});
            for (int i = 0; i < int'(c); i++) xfer_one();
            rd(2'd1, v);
            chk("R7 random source", v, s + (sf ? AW'(c) * step_of(b) : AW'(0)));
            rd(2'd2, v);
            chk("R7 random destination", v, d + (dfe ? AW'(c) * step_of(b) : AW'(0)));
            rd(2'd3, v);
            chk("R8 random count end", v, 16'h0000);
            rd(2'd0, v);
            chk("R9 random enable cleared", v[3], 1'b0);
            chk("R9 random done count", n_done - d0, 1);
        end

        summary();
    end

endmodule